// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block is a byte-addressed GPIO controller. Its `NPINS` pins are split at the pin index `SPLIT` into two banks. Pins below the split form the core bank, and the rest form the resume bank. Each bank has its own block of eight registers, and each register is one bit per pin. Software uses the registers to enable pins, to choose their direction and to drive their output level. It also uses them to pick rising, falling or both-edge triggering, to gate each pin into the interrupt, and to acknowledge events.

Input pins pass through a two-stage synchronizer. An edge is found by comparing the second stage with a third, delayed sample. A detected edge on an enabled input sets a sticky status bit. The status bits that are gated by their event-enable bits are ORed into one level-sensitive interrupt. That interrupt stays high until every gated status bit has been acknowledged. Reads are combinational from `addr`, and a write takes effect on the clock edge where `wr_en` is high.

Top module: `gpio_twobank`

## Requirements
- R1: After reset every pin is an input, so `pin_oe` is 0. The direction bytes read as ones for existing pins: 0x04=0xFF, 0x05=0x03 and 0x24=0x0F with the defaults. Enable, level, edge, event, routing and status registers read 0, and `irq` is 0.
- R2: Pin i is a resume pin when i >= SPLIT, with local index n = i-SPLIT and base 0x20. Otherwise n = i and the base is 0x00. Its bit lies at byte address base + offset + n/8, bit n mod 8. The offsets are: enable 0x00, direction 0x04, level 0x08, rising enable 0x0C, falling enable 0x10, event enable 0x14, routing enable 0x18, status 0x1C.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. `pin_oe` is high exactly when the pin's enable bit is 1 and its direction bit is 0. `pin_out` carries the level bit.
- R4: While a pin is an input, writes to its level bit are ignored and reads of it return the synchronized pin value. While it is an output, reads return the written level.
- R5: A 0-to-1 transition on an input pin whose rising enable is set sets that pin's status bit.
- R6: A 1-to-0 transition on an input pin whose falling enable is set sets its status bit. With both enables set, either transition sets it. With neither set, no transition sets it.
- R7: A status bit is sticky. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R8: When a qualifying edge and a clearing write land on the same clock edge, the status bit stays set.
- R9: `irq` is the OR over pins of status AND event enable. It stays high until those bits are cleared or masked, and a status bit whose event enable is 0 does not raise `irq`.
- R10: Byte addresses that hold no pin bit read 0, and writes to them change nothing. The routing register reads back what was written and does not affect `irq`.
- R11: A pin change applied between clock edges becomes visible in the status register on the third following rising edge and not before. Pins configured as outputs never set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address for read and write |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for `addr` (combinational) |
| pin_in | input | NPINS | Sampled pad values |
| pin_out | output | NPINS | Output drive levels |
| pin_oe | output | NPINS | Output enables |
| irq | output | 1 | Level interrupt |

## Verification
A table of write and read-back pairs covers every register kind in both banks. It includes the partial top bytes and unmapped addresses, which separates correct bank and byte decoding from aliasing. Directed sequences then toggle single pins under rising-only, falling-only and both-edge settings, and on output pins. These sequences distinguish edge polarity selection and the direction qualification. Timed checks before and on the third clock edge pin down the synchronizer latency. A clear write placed on the exact edge where a new edge is detected separates set priority from clear priority. Event-enable and routing toggles show that masking acts on `irq` alone.

// File: rtl/gpio_twobank.sv
`timescale 1ns/1ps
module gpio_twobank #(
  parameter int NPINS  = 14,
  parameter int SPLIT  = 10,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int K_EN = 0, K_DIR = 1, K_LVL = 2, K_RISE = 3;
  localparam int K_FALL = 4, K_EVT = 5, K_ROUTE = 6, K_STS = 7;
  localparam int NCFG = 7;
  localparam int RES_BASE = 32;

  function automatic logic [ADDR_W-1:0] badr(input int i, input int k);
    int loc, base;
    loc  = (i >= SPLIT) ? i - SPLIT : i;
    base = (i >= SPLIT) ? RES_BASE : 0;
    return ADDR_W'(base + 4 * k + loc / 8);
  endfunction

  function automatic logic [2:0] bpos(input int i);
    int loc;
    loc = (i >= SPLIT) ? i - SPLIT : i;
    return 3'(loc % 8);
  endfunction

  logic [NPINS-1:0] cfg [NCFG];
  logic [NPINS-1:0] sts, s1, s2, s3;
  logic [NPINS-1:0] set_v, clr_v, lvl_rd;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      set_v[i] = cfg[K_DIR][i] &
                 ((cfg[K_RISE][i] & s2[i] & ~s3[i]) |
                  (cfg[K_FALL][i] & ~s2[i] & s3[i]));
      clr_v[i] = wr_en && (addr == badr(i, K_STS)) && wdata[bpos(i)];
      lvl_rd[i] = cfg[K_DIR][i] ? s2[i] : cfg[K_LVL][i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCFG; k++) cfg[k] <= '0;
      cfg[K_DIR] <= '1;
      sts <= '0;
      s1  <= '0;
      s2  <= '0;
      s3  <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      for (int i = 0; i < NPINS; i++)
        for (int k = 0; k < NCFG; k++)
          if (wr_en && addr == badr(i, k) && !(k == K_LVL && cfg[K_DIR][i]))
            cfg[k][i] <= wdata[bpos(i)];
      sts <= (sts & ~clr_v) | set_v;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPINS; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (addr == badr(i, k)) begin
          case (k)
            K_LVL:   rdata[bpos(i)] = lvl_rd[i];
            K_STS:   rdata[bpos(i)] = sts[i];
            default: rdata[bpos(i)] = cfg[k][i];
          endcase
        end
      end
    end
  end

  assign pin_out = cfg[K_LVL];
  assign pin_oe  = cfg[K_EN] & ~cfg[K_DIR];
  assign irq     = |(sts & cfg[K_EVT]);

  // R9: with no write, nothing can clear or mask a raised interrupt
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_en |=> irq);

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_chk
    p_sts_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sts[gi] && !(wr_en && addr == badr(gi, K_STS)) |=> sts[gi]);
    p_lvl_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[K_DIR][gi] |=> $stable(cfg[K_LVL][gi]));
    p_dir_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == badr(gi, K_DIR)) |=> $stable(cfg[K_DIR][gi]));
    p_sts_input_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[gi]) |-> $past(cfg[K_DIR][gi]));
  end
endmodule

// File: tb/tb_gpio_twobank.sv
`timescale 1ns/1ps
module tb_gpio_twobank;
  localparam int NPINS = 14;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [NPINS-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int total = 0, bad = 0;

  gpio_twobank #(.NPINS(NPINS), .SPLIT(10), .ADDR_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #4 clk = ~clk;

  // {addr, write data, expected read}
  localparam logic [23:0] VEC [12] = '{
    {8'h00, 8'hFF, 8'hFF}, {8'h01, 8'hFF, 8'h03}, {8'h20, 8'hFF, 8'h0F},
    {8'h04, 8'h0F, 8'h0F}, {8'h0C, 8'hA5, 8'hA5}, {8'h30, 8'h05, 8'h05},
    {8'h38, 8'h03, 8'h03}, {8'h02, 8'hFF, 8'h00}, {8'h21, 8'hFF, 8'h00},
    {8'h19, 8'hFF, 8'h03}, {8'h3F, 8'hFF, 8'h00}, {8'h14, 8'h3C, 8'h3C}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a[5:0]; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a[5:0];
    #1;
    chk(req, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait4();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd("R1 dir core0", 8'h04, 8'hFF);
    rd("R1 dir core1", 8'h05, 8'h03);
    rd("R1 dir res", 8'h24, 8'h0F);
    rd("R1 status", 8'h1C, 8'h00);
    rd("R1 enable", 8'h00, 8'h00);
    chk("R1 oe", pin_oe, 0);
    chk("R1 irq", irq, 0);

    // R2 / R10 table walk
    for (int v = 0; v < 12; v++) begin
      wr(VEC[v][23:16], VEC[v][15:8]);
      rd("R2 R10 map", VEC[v][23:16], VEC[v][7:0]);
    end
    do_reset();

    // R4 level ignored on input, reads synced pin
    wr(8'h08, 8'hFF);
    rd("R4 lvl write ignored", 8'h08, 8'h00);
    @(negedge clk); pin_in[0] = 1;
    @(negedge clk); @(negedge clk);
    rd("R4 lvl reads pin", 8'h08, 8'h01);
    @(negedge clk); pin_in[0] = 0;
    wait4();

    // R3 direction and output enable
    wr(8'h00, 8'hFF);
    wr(8'h04, 8'hF0);
    wr(8'h08, 8'h0A);
    rd("R3 lvl readback", 8'h08, 8'h0A);
    chk("R4 R3 pin_out", pin_out[7:0], 8'h0A);
    chk("R3 pin_oe", pin_oe[7:0], 8'h0F);
    wr(8'h00, 8'h0E);
    chk("R3 enable gates oe", pin_oe[7:0], 8'h0E);

    // R5 / R11 rising on resume pin 11, latency
    wr(8'h2C, 8'h02);
    wr(8'h34, 8'h02);
    @(negedge clk); pin_in[11] = 1;
    @(negedge clk); @(negedge clk);
    rd("R11 not before third edge", 8'h3C, 8'h00);
    @(negedge clk);
    rd("R5 rise sets status", 8'h3C, 8'h02);
    chk("R9 irq raised", irq, 1);

    // R11 output pin does not set status
    wr(8'h0C, 8'h01);
    @(negedge clk); pin_in[0] = 1;
    wait4();
    rd("R11 output no status", 8'h1C, 8'h00);
    pin_in[0] = 0;
    wait4();

    // R9 / R7
    pin_in[11] = 0;
    wait4();
    chk("R9 irq holds", irq, 1);
    wr(8'h3C, 8'h00);
    rd("R7 write0 keeps", 8'h3C, 8'h02);
    wr(8'h3C, 8'h02);
    rd("R7 write1 clears", 8'h3C, 8'h00);
    chk("R9 irq drops", irq, 0);

    // R6 falling and both edges on pins 8,9
    wr(8'h0D, 8'h01);
    wr(8'h11, 8'h03);
    @(negedge clk); pin_in[8] = 1;
    wait4();
    rd("R6 both rise", 8'h1D, 8'h01);
    chk("R9 masked no irq", irq, 0);
    pin_in[9] = 1;
    wait4();
    rd("R6 fall-only ignores rise", 8'h1D, 8'h01);
    wr(8'h1D, 8'h01);
    rd("R7 clear", 8'h1D, 8'h00);
    @(negedge clk); pin_in[8] = 0;
    wait4();
    rd("R6 both fall", 8'h1D, 8'h01);
    pin_in[9] = 0;
    wait4();
    rd("R6 fall", 8'h1D, 8'h03);
    wr(8'h1D, 8'h03);
    rd("R7 clear both", 8'h1D, 8'h00);

    // R8 set wins over simultaneous clear
    @(negedge clk); pin_in[8] = 1;
    @(negedge clk);
    wr(8'h1D, 8'h01);
    rd("R8 set beats clear", 8'h1D, 8'h01);
    wr(8'h1D, 8'h01);
    rd("R8 single event", 8'h1D, 8'h00);

    // R9 event enable gating, R10 routing no effect
    wr(8'h15, 8'h01);
    chk("R9 no status no irq", irq, 0);
    @(negedge clk); pin_in[8] = 0;
    wait4();
    chk("R9 enabled irq", irq, 1);
    wr(8'h15, 8'h00);
    chk("R9 mask drops irq", irq, 0);
    rd("R9 status kept", 8'h1D, 8'h01);
    wr(8'h19, 8'h01);
    chk("R10 routing no irq", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule